// File: doc/BRIEF.md
# Compare-and-Branch Resolution Unit

This block settles conditional branches for a 32-bit core whose instructions are 16 bits wide. A compare operation hands the block two register values, which it stores untouched as a left operand (A) and a right operand (B). No flags are derived at that point. A later branch instruction names one of ten relations: equality, inequality, and the four orderings in both signed and unsigned form. The block evaluates that relation on the stored pair, A against B.

For a branch, the block reports whether it is taken and which address comes next. When taken, that is the branch target, formed from a signed word offset carried in the instruction. Otherwise it is the sequential address. A condition code outside the ten defined relations is reported as illegal. In that case the reported address is the branch's own address, so an exception handler can restart from it. Fetch, the register file and the exception handler itself sit outside this block.

Top module: `bru_branch_unit`

## Requirements
- R1: A synchronous active-high `rst` clears both stored operands to zero and drives `next_pc`, `taken` and `illegal` to zero. After reset, an equality branch is therefore taken.
- R2: On a rising edge with `cmp_en` high, `cmp_lhs` is stored unmodified as A and `cmp_rhs` as B. A branch accepted on the next edge or later uses that pair. A branch accepted on the same edge as a compare uses the pair stored before that compare.
- R3: A branch is accepted only when `br_en` is high and `insn[15:14]` is `2'b11`. With any other value of those bits, `br_en` has no effect and the outputs keep their previous values.
- R4: Condition code `insn[13:10]` value 0 is taken when A equals B. Value 1 is taken when A differs from B.
- R5: Signed relations treat A and B as two's complement. Code 2 is taken when A<B, 3 when A>B, 6 when A>=B and 7 when A<=B.
- R6: Unsigned relations use the same A and B. Code 4 is taken when A<B, 5 when A>B, 8 when A>=B and 9 when A<=B.
- R7: The offset is `insn[9:0]` read as a signed 10-bit count of 2-byte words. The taken target is `cur_pc + 2 + 2*offset`, and the not-taken address is `cur_pc + 2`, both modulo 2^32.
- R8: Condition codes 10 to 15 give `illegal`=1, `taken`=0 and `next_pc` equal to the branch's own `cur_pc`. A legal branch gives `illegal`=0.
- R9: Results appear on the outputs at the edge that accepts the branch, and so can be sampled in the cycle after the strobe. They hold unchanged until the next accepted branch, whatever the other inputs do meanwhile.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| insn | input | 16 | Branch instruction word, sampled while `br_en` is high |
| cur_pc | input | 32 | Address of the instruction in `insn` |
| cmp_en | input | 1 | Stores `cmp_lhs`/`cmp_rhs` as the operand pair |
| cmp_lhs | input | 32 | Left compare operand (A) |
| cmp_rhs | input | 32 | Right compare operand (B) |
| br_en | input | 1 | Branch strobe |
| next_pc | output | 32 | Resolved next address, or the faulting address when illegal |
| taken | output | 1 | The branch relation held |
| illegal | output | 1 | Condition code outside 0..9 |

## Verification
A compare becomes visible one edge after its strobe: the bench drives `cmp_en` on a falling edge, and the earliest branch that may use the pair is driven on the next falling edge. Branch results are registered on the edge that sees `br_en`, so the bench lowers the strobe on the following falling edge and samples `next_pc`, `taken` and `illegal` there, half a cycle after that registering edge. The hold checks sample again after several idle cycles, and after a rejected strobe, to show that nothing moved outside an accepted branch.

// File: rtl/bru_pkg.sv
package bru_pkg;

    // Instruction field layout shared with the decoder
    localparam int CLASS_HI = 15;
    localparam int CLASS_LO = 14;
    localparam int CODE_HI  = 13;
    localparam int CODE_LO  = 10;
    localparam int OFF_HI   = 9;
    localparam int OFF_LO   = 0;

    localparam int NUM_REL  = 10;

    typedef enum logic [3:0] {
        CC_EQ  = 4'd0,
        CC_NE  = 4'd1,
        CC_LT  = 4'd2,
        CC_GT  = 4'd3,
        CC_LTU = 4'd4,
        CC_GTU = 4'd5,
        CC_GE  = 4'd6,
        CC_LE  = 4'd7,
        CC_GEU = 4'd8,
        CC_LEU = 4'd9
    } cond_e;

    // Derive any relation from three primitive comparisons of A against B
    function automatic logic rel_eval(cond_e kind, logic eq, logic lts, logic ltu);
        logic r;
        case (kind)
            CC_EQ:   r = eq;
            CC_NE:   r = !eq;
            CC_LT:   r = lts;
            CC_GT:   r = !lts && !eq;
            CC_LTU:  r = ltu;
            CC_GTU:  r = !ltu && !eq;
            CC_GE:   r = !lts;
            CC_LE:   r = lts || eq;
            CC_GEU:  r = !ltu;
            CC_LEU:  r = ltu || eq;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bru_cond_store.sv
module bru_cond_store #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmp_en,
    input  logic [XLEN-1:0] lhs_in,
    input  logic [XLEN-1:0] rhs_in,
    output logic [XLEN-1:0] lhs_q_o,
    output logic [XLEN-1:0] rhs_q_o
);

    typedef struct packed {
        logic [XLEN-1:0] lhs;
        logic [XLEN-1:0] rhs;
    } pair_t;

    pair_t pair_d, pair_q;

    always_comb begin
        pair_d = pair_q;
        if (cmp_en) begin
            pair_d.lhs = lhs_in;
            pair_d.rhs = rhs_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
        end else begin
            pair_q <= pair_d;
        end
    end

    assign lhs_q_o = pair_q.lhs;
    assign rhs_q_o = pair_q.rhs;

endmodule

// File: rtl/bru_relation.sv
module bru_relation #(
    parameter int XLEN    = 32,
    parameter int CODE_W  = 4,
    parameter int NUM_REL = bru_pkg::NUM_REL
) (
    input  logic [CODE_W-1:0] code,
    input  logic [XLEN-1:0]   lhs,
    input  logic [XLEN-1:0]   rhs,
    output logic              hit,
    output logic              legal
);

    logic               is_eq;
    logic               is_lts;
    logic               is_ltu;
    logic [NUM_REL-1:0] rel_vec;

    assign is_eq  = (lhs == rhs);
    assign is_lts = ($signed(lhs) < $signed(rhs));
    assign is_ltu = (lhs < rhs);

    for (genvar i = 0; i < NUM_REL; i++) begin : g_rel
        localparam bru_pkg::cond_e KIND = bru_pkg::cond_e'(i);
        assign rel_vec[i] = bru_pkg::rel_eval(KIND, is_eq, is_lts, is_ltu);
    end

    always_comb begin
        hit   = 1'b0;
        legal = 1'b0;
        for (int i = 0; i < NUM_REL; i++) begin
            if (code == CODE_W'(i)) begin
                hit   = rel_vec[i];
                legal = 1'b1;
            end
        end
    end

endmodule

// File: rtl/bru_target.sv
module bru_target #(
    parameter int XLEN       = 32,
    parameter int OFF_W      = 10,
    parameter int INSN_BYTES = 2
) (
    input  logic [XLEN-1:0]  pc,
    input  logic [OFF_W-1:0] off,
    output logic [XLEN-1:0]  seq_pc,
    output logic [XLEN-1:0]  tgt_pc
);

    localparam int SHIFT = $clog2(INSN_BYTES);
    localparam int EXT_W = XLEN - OFF_W - SHIFT;

    logic [XLEN-1:0] off_bytes;

    if (SHIFT > 0) begin : g_scaled
        assign off_bytes = {{EXT_W{off[OFF_W-1]}}, off, {SHIFT{1'b0}}};
    end else begin : g_unscaled
        assign off_bytes = {{EXT_W{off[OFF_W-1]}}, off};
    end

    assign seq_pc = pc + XLEN'(INSN_BYTES);
    assign tgt_pc = seq_pc + off_bytes;

endmodule

// File: rtl/bru_branch_unit.sv
module bru_branch_unit #(
    parameter int XLEN       = 32,
    parameter int ILEN       = 16,
    parameter int INSN_BYTES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [ILEN-1:0] insn,
    input  logic [XLEN-1:0] cur_pc,
    input  logic            cmp_en,
    input  logic [XLEN-1:0] cmp_lhs,
    input  logic [XLEN-1:0] cmp_rhs,
    input  logic            br_en,
    output logic [XLEN-1:0] next_pc,
    output logic            taken,
    output logic            illegal
);

    localparam int CODE_W = bru_pkg::CODE_HI - bru_pkg::CODE_LO + 1;
    localparam int OFF_W  = bru_pkg::OFF_HI - bru_pkg::OFF_LO + 1;

    typedef struct packed {
        logic [XLEN-1:0] npc;
        logic            tkn;
        logic            bad;
    } res_t;

    res_t res_d, res_q;

    logic [XLEN-1:0]   opa;
    logic [XLEN-1:0]   opb;
    logic [CODE_W-1:0] code;
    logic [OFF_W-1:0]  off;
    logic              is_branch;
    logic              rel_hit;
    logic              rel_legal;
    logic [XLEN-1:0]   seq_pc;
    logic [XLEN-1:0]   tgt_pc;

    assign code      = insn[bru_pkg::CODE_HI:bru_pkg::CODE_LO];
    assign off       = insn[bru_pkg::OFF_HI:bru_pkg::OFF_LO];
    assign is_branch = insn[bru_pkg::CLASS_HI] && insn[bru_pkg::CLASS_LO];

    bru_cond_store #(.XLEN(XLEN)) u_store (
        .clk     (clk),
        .rst     (rst),
        .cmp_en  (cmp_en),
        .lhs_in  (cmp_lhs),
        .rhs_in  (cmp_rhs),
        .lhs_q_o (opa),
        .rhs_q_o (opb)
    );

    bru_relation #(.XLEN(XLEN), .CODE_W(CODE_W)) u_rel (
        .code  (code),
        .lhs   (opa),
        .rhs   (opb),
        .hit   (rel_hit),
        .legal (rel_legal)
    );

    bru_target #(.XLEN(XLEN), .OFF_W(OFF_W), .INSN_BYTES(INSN_BYTES)) u_tgt (
        .pc     (cur_pc),
        .off    (off),
        .seq_pc (seq_pc),
        .tgt_pc (tgt_pc)
    );

    always_comb begin
        res_d = res_q;
        if (br_en && is_branch) begin
            if (!rel_legal) begin
                res_d.bad = 1'b1;
                res_d.tkn = 1'b0;
                res_d.npc = cur_pc;
            end else begin
                res_d.bad = 1'b0;
                res_d.tkn = rel_hit;
                res_d.npc = rel_hit ? tgt_pc : seq_pc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign next_pc = res_q.npc;
    assign taken   = res_q.tkn;
    assign illegal = res_q.bad;

endmodule

// File: rtl/bru_branch_unit_chk.sv
module bru_branch_unit_chk #(
    parameter int XLEN = 32,
    parameter int ILEN = 16
) (
    input logic            clk,
    input logic            rst,
    input logic [ILEN-1:0] insn,
    input logic [XLEN-1:0] cur_pc,
    input logic            br_en,
    input logic [XLEN-1:0] next_pc,
    input logic            taken,
    input logic            illegal
);

    logic accept;
    logic bad_code;
    assign accept   = br_en && (insn[15:14] == 2'b11);
    assign bad_code = (insn[13:10] > 4'd9);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (next_pc == '0 && !taken && !illegal));

    assert_nonbranch_ignored_R3: assert property (@(posedge clk) disable iff (rst)
        (br_en && !accept) |=> ($stable(next_pc) && $stable(taken) && $stable(illegal)));

    assert_fallthrough_R7: assert property (@(posedge clk) disable iff (rst)
        (accept && !bad_code) |=> (taken || next_pc == $past(cur_pc) + XLEN'(2)));

    assert_illegal_pc_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && bad_code) |=> (illegal && !taken && next_pc == $past(cur_pc)));

    assert_legal_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (accept && !bad_code) |=> !illegal);

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !br_en |=> ($stable(next_pc) && $stable(taken) && $stable(illegal)));

endmodule

bind bru_branch_unit bru_branch_unit_chk #(.XLEN(XLEN), .ILEN(ILEN)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .insn    (insn),
    .cur_pc  (cur_pc),
    .br_en   (br_en),
    .next_pc (next_pc),
    .taken   (taken),
    .illegal (illegal)
);

// File: tb/bru_branch_unit_test.sv
module bru_branch_unit_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] insn = '0;
    logic [31:0] cur_pc = '0;
    logic        cmp_en = 1'b0;
    logic [31:0] cmp_lhs = '0;
    logic [31:0] cmp_rhs = '0;
    logic        br_en = 1'b0;
    logic [31:0] next_pc;
    logic        taken;
    logic        illegal;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bru_branch_unit uut (
        .clk     (clk),
        .rst     (rst),
        .insn    (insn),
        .cur_pc  (cur_pc),
        .cmp_en  (cmp_en),
        .cmp_lhs (cmp_lhs),
        .cmp_rhs (cmp_rhs),
        .br_en   (br_en),
        .next_pc (next_pc),
        .taken   (taken),
        .illegal (illegal)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_br(logic [3:0] code, logic [9:0] off);
        return {2'b11, code, off};
    endfunction

    function automatic logic ref_rel(logic [3:0] code, logic [31:0] a, logic [31:0] b);
        case (code)
            4'd0: return a == b;
            4'd1: return a != b;
            4'd2: return $signed(a) <  $signed(b);
            4'd3: return $signed(a) >  $signed(b);
            4'd4: return a <  b;
            4'd5: return a >  b;
            4'd6: return $signed(a) >= $signed(b);
            4'd7: return $signed(a) <= $signed(b);
            4'd8: return a >= b;
            4'd9: return a <= b;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] ref_tgt(logic [31:0] pc, logic [9:0] off);
        return pc + 32'd2 + {{21{off[9]}}, off, 1'b0};
    endfunction

    task automatic do_compare(logic [31:0] a, logic [31:0] b);
        @(negedge clk);
        cmp_en = 1'b1; cmp_lhs = a; cmp_rhs = b;
        @(negedge clk);
        cmp_en = 1'b0;
    endtask

    task automatic do_branch(logic [15:0] word, logic [31:0] pc);
        @(negedge clk);
        insn = word; cur_pc = pc; br_en = 1'b1;
        @(negedge clk);
        br_en = 1'b0;
    endtask

    task automatic check_legal(string req, logic [3:0] code, logic [9:0] off,
                               logic [31:0] pc, logic [31:0] a, logic [31:0] b);
        logic t;
        do_branch(mk_br(code, off), pc);
        t = ref_rel(code, a, b);
        chk(req, {31'd0, taken}, {31'd0, t});
        chk(req, next_pc, t ? ref_tgt(pc, off) : pc + 32'd2);
        chk(req, {31'd0, illegal}, 32'd0);
    endtask

    task automatic test_reset();
        chk("R1", next_pc, 32'd0);
        chk("R1", {31'd0, taken}, 32'd0);
        chk("R1", {31'd0, illegal}, 32'd0);
        // cleared operands compare equal
        check_legal("R1", 4'd0, 10'd8, 32'h0000_1000, 32'd0, 32'd0);
    endtask

    task automatic test_eq_ne();
        do_compare(32'h1234_5678, 32'h1234_5678);
        check_legal("R4", 4'd0, 10'd4, 32'h100, 32'h1234_5678, 32'h1234_5678);
        check_legal("R4", 4'd1, 10'd4, 32'h100, 32'h1234_5678, 32'h1234_5678);
        do_compare(32'h1234_5678, 32'h1234_5679);
        check_legal("R4", 4'd0, 10'd4, 32'h200, 32'h1234_5678, 32'h1234_5679);
        check_legal("R4", 4'd1, 10'd4, 32'h200, 32'h1234_5678, 32'h1234_5679);
    endtask

    task automatic test_signed_unsigned();
        logic [31:0] pa [3];
        logic [31:0] pb [3];
        pa[0] = 32'hFFFF_FFFB; pb[0] = 32'd3;
        pa[1] = 32'd3;         pb[1] = 32'hFFFF_FFFB;
        pa[2] = 32'h8000_0000; pb[2] = 32'h8000_0000;
        for (int p = 0; p < 3; p++) begin
            do_compare(pa[p], pb[p]);
            check_legal("R5", 4'd2, 10'd20, 32'h400, pa[p], pb[p]);
            check_legal("R5", 4'd3, 10'd20, 32'h400, pa[p], pb[p]);
            check_legal("R5", 4'd6, 10'd20, 32'h400, pa[p], pb[p]);
            check_legal("R5", 4'd7, 10'd20, 32'h400, pa[p], pb[p]);
            check_legal("R6", 4'd4, 10'h3F0, 32'h800, pa[p], pb[p]);
            check_legal("R6", 4'd5, 10'h3F0, 32'h800, pa[p], pb[p]);
            check_legal("R6", 4'd8, 10'h3F0, 32'h800, pa[p], pb[p]);
            check_legal("R6", 4'd9, 10'h3F0, 32'h800, pa[p], pb[p]);
        end
    endtask

    task automatic test_offsets();
        do_compare(32'd7, 32'd7);
        check_legal("R7", 4'd0, 10'h1FF, 32'h0001_0000, 32'd7, 32'd7);
        chk("R7", next_pc, 32'h0001_0400);
        check_legal("R7", 4'd0, 10'h200, 32'h0001_0000, 32'd7, 32'd7);
        chk("R7", next_pc, 32'h0000_FC02);
        check_legal("R7", 4'd0, 10'h000, 32'hFFFF_FFFE, 32'd7, 32'd7);
        chk("R7", next_pc, 32'h0000_0000);
        check_legal("R7", 4'd1, 10'h1FF, 32'h0000_3000, 32'd7, 32'd7);
        chk("R7", next_pc, 32'h0000_3002);
    endtask

    task automatic test_illegal();
        for (int c = 10; c < 16; c++) begin
            do_branch(mk_br(4'(c), 10'h055), 32'h0000_A000 + 32'(c * 2));
            chk("R8", {31'd0, illegal}, 32'd1);
            chk("R8", {31'd0, taken}, 32'd0);
            chk("R8", next_pc, 32'h0000_A000 + 32'(c * 2));
        end
        check_legal("R8", 4'd0, 10'd2, 32'h50, 32'd7, 32'd7);
    endtask

    task automatic test_nonbranch();
        logic [31:0] held;
        check_legal("R3", 4'd1, 10'd2, 32'h600, 32'd7, 32'd7);
        held = next_pc;
        do_branch(16'h8000, 32'h9000);
        chk("R3", next_pc, held);
        chk("R3", {31'd0, taken}, 32'd0);
        do_branch(16'h4000, 32'h9100);
        chk("R3", next_pc, held);
        do_branch(16'h3C00, 32'h9200);
        chk("R3", {31'd0, illegal}, 32'd0);
        chk("R3", next_pc, held);
    endtask

    task automatic test_same_cycle();
        do_compare(32'd1, 32'd1);
        // compare and branch on the same edge: old pair (equal) must be used
        @(negedge clk);
        cmp_en = 1'b1; cmp_lhs = 32'd1; cmp_rhs = 32'd2;
        insn = mk_br(4'd0, 10'd6); cur_pc = 32'h700; br_en = 1'b1;
        @(negedge clk);
        cmp_en = 1'b0; br_en = 1'b0;
        chk("R2", {31'd0, taken}, 32'd1);
        chk("R2", next_pc, ref_tgt(32'h700, 10'd6));
        // next branch sees new pair
        check_legal("R2", 4'd0, 10'd6, 32'h800, 32'd1, 32'd2);
        check_legal("R2", 4'd4, 10'd6, 32'h800, 32'd1, 32'd2);
    endtask

    task automatic test_hold();
        logic [31:0] held;
        do_compare(32'd9, 32'd2);
        check_legal("R9", 4'd5, 10'd12, 32'hB00, 32'd9, 32'd2);
        held = next_pc;
        @(negedge clk);
        cur_pc = 32'hDEAD_0000; insn = mk_br(4'd14, 10'd0);
        cmp_en = 1'b1; cmp_lhs = 32'd0; cmp_rhs = 32'd5;
        @(negedge clk);
        cmp_en = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9", next_pc, held);
        chk("R9", {31'd0, taken}, 32'd1);
        chk("R9", {31'd0, illegal}, 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_eq_ne();
        test_signed_unsigned();
        test_offsets();
        test_illegal();
        test_nonbranch();
        test_same_cycle();
        test_hold();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule